// File: doc/BRIEF.md
# Barrier and Eureka Synchronization Bank

This block holds a bank of independent hardware synchronization units for one processor. Software reaches each unit as its own memory-mapped register. A write to a unit carries a command and a read returns the unit's state. A unit can serve as a split-phase barrier. The processor arms it, the unit reports its arrival to the combining network, and the unit drops back to idle once the network says that every member of its group has arrived.

A unit can also carry a eureka, which is an event that any member of a group announces to the whole group. When the local processor announces one, the unit sends it to the network and waits in a pending state. It cannot announce another until the group has received the first. When the network delivers a eureka, whether it came from this processor or from another member, the unit arms a barrier across the same group at once.

Traffic to and from the network uses its own dedicated pulse ports, apart from any ordinary memory path. These ports are an arrival port, a eureka-send port, a completion port and a eureka-delivery port. When several units arm in the same cycle, their arrival pulses leave one per cycle, lowest index first.

Top module: `sync_bank`

## Requirements
- R1: After synchronous reset every unit reads as idle (state 2'b00) with its error bit clear, and no arrival or eureka-send pulse is driven.
- R2: Writing command 2'b01 (arm) to an idle unit moves it to armed (2'b01). One cycle later the block drives a single one-cycle arrival pulse carrying that unit's index.
- R3: A completion pulse naming an armed unit returns that unit to idle. A completion pulse naming a unit that is not armed changes nothing.
- R4: Completion pulses may arrive in any order, and each one affects only the unit it names.
- R5: An arm command to a unit that is armed or eureka-pending is ignored. It sets that unit's sticky error bit, which reads as bit 2 of the read data.
- R6: Writing command 2'b10 (eureka) to an idle unit moves it to eureka-pending (2'b10). One cycle later the block drives a one-cycle eureka-send pulse with that unit's index.
- R7: A eureka command to a unit that is not idle is ignored, sends nothing and sets its sticky error bit.
- R8: A eureka delivery from the network to an idle or eureka-pending unit moves it to armed and produces an arrival pulse for it, so the barrier follows at once.
- R9: When several units arm in the same cycle, each gets exactly one arrival pulse. The pulses leave on consecutive cycles, lowest index first.
- R10: Command 2'b11 clears the named unit's error bit and leaves its state unchanged.
- R11: Read data is registered. In the cycle after an index is presented, the read data shows {error, state[1:0]} as they stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Unit addressed by the write |
| wr_cmd | input | 2 | Command: 00 none, 01 arm, 10 eureka, 11 clear error |
| rd_idx | input | 5 | Unit addressed by the read |
| rd_data | output | 3 | Registered {error, state} of the addressed unit |
| arrive_valid | output | 1 | One-cycle arrival pulse to the network |
| arrive_idx | output | 5 | Unit index of the arrival |
| eur_send_valid | output | 1 | One-cycle eureka announcement to the network |
| eur_send_idx | output | 5 | Unit index of the announcement |
| done_valid | input | 1 | One-cycle barrier completion from the network |
| done_idx | input | 5 | Unit index of the completion |
| eur_rcv_valid | input | 1 | One-cycle eureka delivery from the network |
| eur_rcv_idx | input | 5 | Unit index of the delivery |

## Verification
A unit whose state machine goes wrong shows up at the ports in one of two ways. The next read of that index, one cycle later, returns the wrong code. The unit may also send a missing, duplicated or misrouted arrival or eureka pulse, and this appears no more than a cycle after the arming event, or several cycles later when other arrivals are queued ahead of it. Error-bit faults show on the read of bit 2 right after the offending write. Arbitration faults show as a wrong order, or a wrong count, in the arrival pulses that the bench's network model records.

// File: rtl/sync_pkg.sv
package sync_pkg;
  typedef logic [1:0] sync_st_t;
  localparam sync_st_t ST_IDLE  = 2'b00;
  localparam sync_st_t ST_ARMED = 2'b01;
  localparam sync_st_t ST_EPEND = 2'b10;

  localparam logic [1:0] CMD_NONE = 2'b00;
  localparam logic [1:0] CMD_ARM  = 2'b01;
  localparam logic [1:0] CMD_EUR  = 2'b10;
  localparam logic [1:0] CMD_CLR  = 2'b11;
endpackage

// File: rtl/sync_unit.sv
module sync_unit
  import sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic [1:0] cmd,
  input  logic       done_hit,
  input  logic       eur_hit,
  input  logic       grant,
  output sync_st_t   st,
  output logic       err,
  output logic       req,
  output logic       eur_ok
);
  sync_st_t nxt;
  logic net_take, wr_ok, wr_bad, is_start, arm_evt;

  always_comb begin
    nxt      = st;
    net_take = 1'b0;
    case (st)
      ST_IDLE:  if (eur_hit)  begin nxt = ST_ARMED; net_take = 1'b1; end
      ST_ARMED: if (done_hit) begin nxt = ST_IDLE;  net_take = 1'b1; end
      ST_EPEND: if (eur_hit)  begin nxt = ST_ARMED; net_take = 1'b1; end
      default:  nxt = ST_IDLE;
    endcase
    // network events win; a write that collides with one is rejected
    is_start = (cmd == CMD_ARM) || (cmd == CMD_EUR);
    wr_ok    = wr_hit && is_start && !net_take && (st == ST_IDLE);
    wr_bad   = wr_hit && is_start && !wr_ok;
    if (wr_ok) nxt = (cmd == CMD_ARM) ? ST_ARMED : ST_EPEND;
    eur_ok   = wr_ok && (cmd == CMD_EUR);
    arm_evt  = (nxt == ST_ARMED) && (st != ST_ARMED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      err <= 1'b0;
      req <= 1'b0;
    end else begin
      st  <= nxt;
      if (wr_hit && cmd == CMD_CLR) err <= 1'b0;
      else if (wr_bad)              err <= 1'b1;
      req <= (req && !grant) || arm_evt;
    end
  end
endmodule

// File: rtl/sync_pick.sv
module sync_pick #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    any   = |req;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        grant = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_bank.sv
module sync_bank
  import sync_pkg::*;
#(
  parameter int N_UNITS = 32,
  parameter int IDX_W   = $clog2(N_UNITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_cmd,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [2:0]       rd_data,
  output logic             arrive_valid,
  output logic [IDX_W-1:0] arrive_idx,
  output logic             eur_send_valid,
  output logic [IDX_W-1:0] eur_send_idx,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_idx,
  input  logic             eur_rcv_valid,
  input  logic [IDX_W-1:0] eur_rcv_idx
);
  sync_st_t [N_UNITS-1:0] st;
  logic [N_UNITS-1:0] err, req, grant, eur_ok;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    sync_unit u_unit (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (wr_en && wr_idx == IDX_W'(g)),
      .cmd      (wr_cmd),
      .done_hit (done_valid && done_idx == IDX_W'(g)),
      .eur_hit  (eur_rcv_valid && eur_rcv_idx == IDX_W'(g)),
      .grant    (grant[g]),
      .st       (st[g]),
      .err      (err[g]),
      .req      (req[g]),
      .eur_ok   (eur_ok[g])
    );
  end

  sync_pick #(.N(N_UNITS), .IDX_W(IDX_W)) u_pick (
    .req   (req),
    .any   (pick_any),
    .idx   (pick_idx),
    .grant (grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data        <= '0;
      arrive_valid   <= 1'b0;
      arrive_idx     <= '0;
      eur_send_valid <= 1'b0;
      eur_send_idx   <= '0;
    end else begin
      rd_data        <= {err[rd_idx], st[rd_idx]};
      arrive_valid   <= pick_any;
      arrive_idx     <= pick_idx;
      eur_send_valid <= |eur_ok;
      eur_send_idx   <= wr_idx;
    end
  end
endmodule

// File: rtl/sync_bank_chk.sv
module sync_bank_chk
  import sync_pkg::*;
#(
  parameter int N_UNITS = 32,
  parameter int IDX_W   = $clog2(N_UNITS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [1:0]             wr_cmd,
  input logic                   arrive_valid,
  input logic [IDX_W-1:0]       arrive_idx,
  input logic                   eur_send_valid,
  input logic [IDX_W-1:0]       eur_send_idx,
  input logic                   done_valid,
  input logic [IDX_W-1:0]       done_idx,
  input sync_st_t [N_UNITS-1:0] st,
  input logic [N_UNITS-1:0]     err
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!arrive_valid && !eur_send_valid));

  p_arrive_armed_r2: assert property (@(posedge clk) disable iff (rst)
    arrive_valid |-> (st[arrive_idx] == ST_ARMED));

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (done_valid && st[done_idx] == ST_ARMED) |=> (st[$past(done_idx)] == ST_IDLE));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && wr_cmd == CMD_CLR) |-> ((err & $past(err)) == $past(err)));

  p_send_pending_r6: assert property (@(posedge clk) disable iff (rst)
    eur_send_valid |-> (st[eur_send_idx] == ST_EPEND));
endmodule

bind sync_bank sync_bank_chk #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd),
  .arrive_valid(arrive_valid), .arrive_idx(arrive_idx),
  .eur_send_valid(eur_send_valid), .eur_send_idx(eur_send_idx),
  .done_valid(done_valid), .done_idx(done_idx), .st(st), .err(err)
);

// File: tb/sync_bank_tb_top.sv
module sync_bank_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, wr_en, done_valid, eur_rcv_valid;
  logic [4:0] wr_idx, rd_idx, done_idx, eur_rcv_idx, arrive_idx, eur_send_idx;
  logic [1:0] wr_cmd;
  logic [2:0] rd_data;
  logic       arrive_valid, eur_send_valid;

  sync_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_cmd(wr_cmd),
    .rd_idx(rd_idx), .rd_data(rd_data), .arrive_valid(arrive_valid),
    .arrive_idx(arrive_idx), .eur_send_valid(eur_send_valid),
    .eur_send_idx(eur_send_idx), .done_valid(done_valid), .done_idx(done_idx),
    .eur_rcv_valid(eur_rcv_valid), .eur_rcv_idx(eur_rcv_idx)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  int arr_cnt [32];
  int eur_cnt [32];
  int ord [16];
  int n_ord = 0;

  // network model: record every pulse the block sends
  always @(negedge clk) begin
    if (!rst && arrive_valid) begin
      arr_cnt[arrive_idx]++;
      if (n_ord < 16) ord[n_ord] = int'(arrive_idx);
      n_ord++;
    end
    if (!rst && eur_send_valid) eur_cnt[eur_send_idx]++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [1:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_cmd = c;
    @(negedge clk);
    wr_en = 1'b0; wr_cmd = 2'b00;
  endtask

  task automatic net_done(input int idx);
    @(negedge clk);
    done_valid = 1'b1; done_idx = 5'(idx);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic net_eur(input int idx);
    @(negedge clk);
    eur_rcv_valid = 1'b1; eur_rcv_idx = 5'(idx);
    @(negedge clk);
    eur_rcv_valid = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input int exp, input string rq);
    @(negedge clk);
    rd_idx = 5'(idx);
    @(negedge clk);
    chk(rd_data == 3'(exp), rq, int'(rd_data), exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // {unit[4:0], cmd[1:0], err, state[1:0]}
  localparam logic [9:0] VEC [8] = '{
    {5'd3,  2'b01, 1'b0, 2'b01},  // R2 arm idle unit
    {5'd3,  2'b01, 1'b1, 2'b01},  // R5 re-arm rejected
    {5'd3,  2'b11, 1'b0, 2'b01},  // R10 clear error only
    {5'd7,  2'b10, 1'b0, 2'b10},  // R6 eureka from idle
    {5'd7,  2'b01, 1'b1, 2'b10},  // R5 arm while pending
    {5'd7,  2'b10, 1'b1, 2'b10},  // R7 second eureka rejected
    {5'd0,  2'b00, 1'b0, 2'b00},  // no-op command
    {5'd31, 2'b01, 1'b0, 2'b01}   // R2 top index
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin arr_cnt[i] = 0; eur_cnt[i] = 0; end
    rst = 1'b1; wr_en = 0; wr_idx = 0; wr_cmd = 0; rd_idx = 0;
    done_valid = 0; done_idx = 0; eur_rcv_valid = 0; eur_rcv_idx = 0;
    repeat (4) @(negedge clk);
    chk(!arrive_valid && !eur_send_valid, "R1 pulses in reset", int'(arrive_valid), 0);
    rst = 1'b0;
    rd_chk(0, 0, "R1 unit0 after reset");
    rd_chk(31, 0, "R1 unit31 after reset");

    for (int v = 0; v < 8; v++) begin
      wr(int'(VEC[v][9:5]), VEC[v][4:3]);
      rd_chk(int'(VEC[v][9:5]), int'(VEC[v][2:0]), "R2/R5/R6/R7/R10 vector");
    end
    settle();
    chk(arr_cnt[3] == 1, "R2 arrival count unit3", arr_cnt[3], 1);
    chk(arr_cnt[31] == 1, "R2 arrival count unit31", arr_cnt[31], 1);
    chk(eur_cnt[7] == 1, "R6 R7 eureka sends unit7", eur_cnt[7], 1);
    chk(arr_cnt[7] == 0, "R5 no arrival for pending unit", arr_cnt[7], 0);

    // R4: complete in opposite order to arming
    net_done(31);
    rd_chk(31, 0, "R4 unit31 idle");
    rd_chk(3, 1, "R4 unit3 still armed");
    net_done(3);
    rd_chk(3, 0, "R3 unit3 idle");
    rd_chk(7, 6, "R4 unit7 untouched");
    net_done(0);
    rd_chk(0, 0, "R3 completion to idle ignored");
    net_done(7);
    rd_chk(7, 6, "R3 completion to pending ignored");

    // R8: eureka delivery to pending and to idle unit
    net_eur(7);
    rd_chk(7, 5, "R8 pending unit armed");
    net_eur(9);
    rd_chk(9, 1, "R8 idle unit armed");
    settle();
    chk(arr_cnt[7] == 1, "R8 arrival unit7", arr_cnt[7], 1);
    chk(arr_cnt[9] == 1, "R8 arrival unit9", arr_cnt[9], 1);
    net_done(7); net_done(9);
    rd_chk(9, 0, "R3 unit9 idle");

    // R9: two units arm in one cycle
    n_ord = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_cmd = 2'b01;
    eur_rcv_valid = 1'b1; eur_rcv_idx = 5'd2;
    @(negedge clk);
    wr_en = 1'b0; wr_cmd = 2'b00; eur_rcv_valid = 1'b0;
    settle();
    chk(n_ord == 2, "R9 arrival count", n_ord, 2);
    chk(ord[0] == 2, "R9 first arrival", ord[0], 2);
    chk(ord[1] == 5, "R9 second arrival", ord[1], 5);
    net_done(2); net_done(5);

    // R11: read shows pre-edge value
    @(negedge clk);
    rd_idx = 5'd10; wr_en = 1'b1; wr_idx = 5'd10; wr_cmd = 2'b01;
    @(negedge clk);
    wr_en = 1'b0; wr_cmd = 2'b00;
    chk(rd_data == 3'd0, "R11 old value first", int'(rd_data), 0);
    @(negedge clk);
    chk(rd_data == 3'd1, "R11 new value next", int'(rd_data), 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule